// File: doc/BRIEF.md
# Cable Diagnostic Test Sequencer

This block runs one cable integrity test at a time on an Ethernet PHY, using only management-register transactions. A one-cycle start pulse launches either a reflectometry test or an active-link cable length test. The sequencer points the PHY's result selector at the wanted result, starts the test, and polls the PHY's status register until that test's completion bit appears. A reflectometry test can report failure. If the test did not fail, the sequencer fetches the result register and presents it. The outcome is announced with a one-cycle done pulse.

All register traffic leaves through a request/acknowledge port, with one transaction in flight at a time. A management-bus serializer sits behind this port and turns each request into bus frames. Every change to the control register is a read followed by a write, so bits the test does not own keep their values. A poll limit, given as an input, bounds the wait for completion. If the limit is reached, the test is abandoned and a timeout is flagged.

Top module: `cable_diag_seq`

## Requirements
- R1: After reset, and whenever the block is idle, `busy_o`, `done_o` and `mgmt_req_o` are 0, and `result_o`, `fail_o` and `timeout_o` are cleared by reset.
- R2: Every transaction carries PHY address 1. A reflectometry run reads the control register (default address 0x1E) and writes it back with bits 10:8 set to `set_idx_i` and every other bit unchanged. It then reads the control register again and writes it back with bit 12 set and every other bit unchanged.
- R3: An active-link run uses the same read-modify-write pair. It writes the code 6 into bits 10:8, whatever `set_idx_i` holds, and then sets bit 13.
- R4: After starting the test, the block reads the status register (default 0x1F) repeatedly. Completion is status bit 13 for reflectometry and status bit 15 for active-link; the other test's bits are ignored. On completion without failure, the block reads the result register (default 0x1D) once, presents its value on `result_o` and pulses `done_o`.
- R5: For reflectometry, status bit 14 read together with the completion bit marks failure. The block then sets `fail_o`, skips the result read, and leaves `result_o` at 0. Bit 14 has no meaning for active-link.
- R6: If `timeout_limit_i` consecutive status reads (at least one) all lack the completion bit, the block sets `timeout_o`, issues no further transaction and pulses `done_o`. A completion bit seen on the last allowed read counts as success.
- R7: `mgmt_req_o` is held high with stable address, write flag and write data until the cycle in which `mgmt_ack_i` is 1. It is low in the following cycle.
- R8: A start pulse that arrives while `busy_o` is 1 is ignored.
- R9: `done_o` is high for exactly one clock cycle per run. `busy_o` is 0 in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a test |
| test_sel_i | input | 1 | 0 = reflectometry, 1 = active-link length |
| set_idx_i | input | 3 | Reflectometry result-set index (0 to 4) |
| timeout_limit_i | input | 8 | Number of status reads allowed |
| busy_o | output | 1 | A test is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 16 | Result register value from the last successful run |
| fail_o | output | 1 | Last run reported failure |
| timeout_o | output | 1 | Last run ran out of polls |
| mgmt_req_o | output | 1 | Management transaction request |
| mgmt_we_o | output | 1 | 1 = write, 0 = read |
| mgmt_phy_o | output | 5 | PHY address |
| mgmt_reg_o | output | 5 | Register address |
| mgmt_wdata_o | output | 16 | Write data |
| mgmt_ack_i | input | 1 | Transaction complete |
| mgmt_rdata_i | input | 16 | Read data, valid with ack |

## Verification
The completion bit and the poll limit can resolve on the same status read. The bench provokes this by setting the limit to four and having the PHY model show completion on exactly the fourth read. It expects a success with a fetched result, no timeout, and four status reads. A second collision happens when a start pulse lands mid-run. It must neither restart the register sequence nor alter the outcome of the run already in progress. The bench judges this from the logged transaction stream and the reported result.

// File: rtl/cdiag_pkg.sv
package cdiag_pkg;
  localparam int unsigned REG_W = 16;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned SEL_LO = 8;
  localparam int unsigned SEL_HI = 10;
  localparam int unsigned REFL_GO_BIT = 12;
  localparam int unsigned LEN_GO_BIT = 13;
  localparam int unsigned REFL_DONE_BIT = 13;
  localparam int unsigned REFL_FAIL_BIT = 14;
  localparam int unsigned LEN_DONE_BIT = 15;
  localparam logic [2:0] LEN_SEL_CODE = 3'd6;

  typedef enum logic {TEST_REFL = 1'b0, TEST_LEN = 1'b1} test_e;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_SEL, S_WR_SEL, S_RD_GO, S_WR_GO, S_POLL, S_RD_RES, S_FIN
  } state_e;
endpackage

// File: rtl/cdiag_mgmt_port.sv
module cdiag_mgmt_port #(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 5,
  parameter logic [4:0] PHY_ADDR = 5'd1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue_i,
  input  logic          we_i,
  input  logic [AW-1:0] reg_i,
  input  logic [DW-1:0] wdata_i,
  output logic          xfer_done_o,
  output logic          req_o,
  output logic          we_o,
  output logic [4:0]    phy_o,
  output logic [AW-1:0] reg_o,
  output logic [DW-1:0] wdata_o,
  input  logic          ack_i
);
  logic          req_q, req_d;
  logic          we_q;
  logic [AW-1:0] reg_q;
  logic [DW-1:0] wdata_q;
  logic          ld_en;

  assign ld_en = issue_i;

  always_comb begin
    req_d = req_q;
    if (req_q && ack_i) req_d = 1'b0;
    if (issue_i) req_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q    <= 1'b0;
      reg_q   <= '0;
      wdata_q <= '0;
    end else if (ld_en) begin
      we_q    <= we_i;
      reg_q   <= reg_i;
      wdata_q <= wdata_i;
    end
  end

  assign xfer_done_o = req_q & ack_i;
  assign req_o   = req_q;
  assign we_o    = we_q;
  assign phy_o   = PHY_ADDR;
  assign reg_o   = reg_q;
  assign wdata_o = wdata_q;

  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_q && !ack_i |=> req_q && $stable(reg_q) && $stable(we_q) && $stable(wdata_q));

  assert_req_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_q && ack_i |=> !req_q);

  assert_single_outstanding_R7: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i |-> !req_q);
endmodule

// File: rtl/cdiag_poll_timer.sv
module cdiag_poll_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          miss_i,
  input  logic [CW-1:0] limit_i,
  output logic          last_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = clr_i | miss_i;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)       cnt_d = '0;
    else if (miss_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // The current miss is the last one allowed when it brings the count to the limit.
  assign last_o = ({1'b0, cnt_q} + {{CW{1'b0}}, 1'b1}) >= {1'b0, limit_i};

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> cnt_q == '0);
endmodule

// File: rtl/cdiag_word_build.sv
module cdiag_word_build
  import cdiag_pkg::*;
(
  input  test_e            test_i,
  input  logic [2:0]       idx_i,
  input  logic             go_phase_i,
  input  logic [REG_W-1:0] ctl_i,
  input  logic [REG_W-1:0] status_i,
  output logic [REG_W-1:0] wdata_o,
  output logic             sts_done_o,
  output logic             sts_fail_o
);
  logic [2:0] sel;

  assign sel = (test_i == TEST_LEN) ? LEN_SEL_CODE : idx_i;

  always_comb begin
    wdata_o = ctl_i;
    if (go_phase_i) begin
      if (test_i == TEST_LEN) wdata_o[LEN_GO_BIT]  = 1'b1;
      else                    wdata_o[REFL_GO_BIT] = 1'b1;
    end else begin
      wdata_o[SEL_HI:SEL_LO] = sel;
    end
  end

  assign sts_done_o = (test_i == TEST_LEN) ? status_i[LEN_DONE_BIT] : status_i[REFL_DONE_BIT];
  assign sts_fail_o = (test_i == TEST_REFL) & status_i[REFL_FAIL_BIT];
endmodule

// File: rtl/cable_diag_seq.sv
module cable_diag_seq
  import cdiag_pkg::*;
#(
  parameter int unsigned TO_W = 8,
  parameter logic [4:0] PHY_ADDR = 5'd1,
  parameter logic [4:0] CTL_ADDR = 5'h1E,
  parameter logic [4:0] STS_ADDR = 5'h1F,
  parameter logic [4:0] RES_ADDR = 5'h1D
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            test_sel_i,
  input  logic [2:0]      set_idx_i,
  input  logic [TO_W-1:0] timeout_limit_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [15:0]     result_o,
  output logic            fail_o,
  output logic            timeout_o,
  output logic            mgmt_req_o,
  output logic            mgmt_we_o,
  output logic [4:0]      mgmt_phy_o,
  output logic [4:0]      mgmt_reg_o,
  output logic [15:0]     mgmt_wdata_o,
  input  logic            mgmt_ack_i,
  input  logic [15:0]     mgmt_rdata_i
);
  state_e           state_q, state_d;
  logic             launched_q, launched_d;
  test_e            test_q, test_d;
  logic [2:0]       idx_q, idx_d;
  logic [REG_W-1:0] ctl_q, ctl_d;
  logic [REG_W-1:0] res_q, res_d;
  logic             fail_q, fail_d;
  logic             to_q, to_d;

  logic             txn_state, issue, xfer;
  logic             we_sel;
  logic [4:0]       reg_sel;
  logic [REG_W-1:0] wword;
  logic             sts_done, sts_fail;
  logic             timer_clr, timer_miss, timer_last;
  logic             accept;

  assign txn_state = (state_q != S_IDLE) && (state_q != S_FIN);
  assign issue     = txn_state && !launched_q;
  assign we_sel    = (state_q == S_WR_SEL) || (state_q == S_WR_GO);
  assign accept    = (state_q == S_IDLE) && start_i;

  always_comb begin
    unique case (state_q)
      S_POLL:   reg_sel = STS_ADDR;
      S_RD_RES: reg_sel = RES_ADDR;
      default:  reg_sel = CTL_ADDR;
    endcase
  end

  cdiag_word_build u_build (
    .test_i     (test_q),
    .idx_i      (idx_q),
    .go_phase_i (state_q == S_WR_GO),
    .ctl_i      (ctl_q),
    .status_i   (mgmt_rdata_i),
    .wdata_o    (wword),
    .sts_done_o (sts_done),
    .sts_fail_o (sts_fail)
  );

  cdiag_mgmt_port #(.DW(REG_W), .AW(ADDR_W), .PHY_ADDR(PHY_ADDR)) u_port (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_i     (issue),
    .we_i        (we_sel),
    .reg_i       (reg_sel),
    .wdata_i     (wword),
    .xfer_done_o (xfer),
    .req_o       (mgmt_req_o),
    .we_o        (mgmt_we_o),
    .phy_o       (mgmt_phy_o),
    .reg_o       (mgmt_reg_o),
    .wdata_o     (mgmt_wdata_o),
    .ack_i       (mgmt_ack_i)
  );

  assign timer_clr  = accept;
  assign timer_miss = (state_q == S_POLL) && xfer && !sts_done;

  cdiag_poll_timer #(.CW(TO_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (timer_clr),
    .miss_i  (timer_miss),
    .limit_i (timeout_limit_i),
    .last_o  (timer_last)
  );

  always_comb begin
    state_d    = state_q;
    test_d     = test_q;
    idx_d      = idx_q;
    ctl_d      = ctl_q;
    res_d      = res_q;
    fail_d     = fail_q;
    to_d       = to_q;
    launched_d = launched_q;
    if (xfer)       launched_d = 1'b0;
    else if (issue) launched_d = 1'b1;

    unique case (state_q)
      S_IDLE: begin
        if (start_i) begin
          state_d = S_RD_SEL;
          test_d  = test_e'(test_sel_i);
          idx_d   = set_idx_i;
          res_d   = '0;
          fail_d  = 1'b0;
          to_d    = 1'b0;
        end
      end
      S_RD_SEL: if (xfer) begin ctl_d = mgmt_rdata_i; state_d = S_WR_SEL; end
      S_WR_SEL: if (xfer) state_d = S_RD_GO;
      S_RD_GO:  if (xfer) begin ctl_d = mgmt_rdata_i; state_d = S_WR_GO; end
      S_WR_GO:  if (xfer) state_d = S_POLL;
      S_POLL: begin
        if (xfer) begin
          if (sts_done) begin
            if (sts_fail) begin fail_d = 1'b1; state_d = S_FIN; end
            else          state_d = S_RD_RES;
          end else if (timer_last) begin
            to_d    = 1'b1;
            state_d = S_FIN;
          end
        end
      end
      S_RD_RES: if (xfer) begin res_d = mgmt_rdata_i; state_d = S_FIN; end
      S_FIN:    state_d = S_IDLE;
      default:  state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      launched_q <= 1'b0;
      test_q     <= TEST_REFL;
      idx_q      <= '0;
      ctl_q      <= '0;
      res_q      <= '0;
      fail_q     <= 1'b0;
      to_q       <= 1'b0;
    end else begin
      state_q    <= state_d;
      launched_q <= launched_d;
      test_q     <= test_d;
      idx_q      <= idx_d;
      ctl_q      <= ctl_d;
      res_q      <= res_d;
      fail_q     <= fail_d;
      to_q       <= to_d;
    end
  end

  assign busy_o    = state_q != S_IDLE;
  assign done_o    = state_q == S_FIN;
  assign result_o  = res_q;
  assign fail_o    = fail_q;
  assign timeout_o = to_q;

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o && !busy_o);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !mgmt_req_o);

  assert_outcome_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !(fail_o && timeout_o));

  assert_fail_noresult_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && fail_o |-> result_o == '0);

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !done_o |=> busy_o);
endmodule

// File: tb/sim_cable_diag_seq.sv
module sim_cable_diag_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        test_sel_i = 1'b0;
  logic [2:0]  set_idx_i = 3'd0;
  logic [7:0]  timeout_limit_i = 8'd20;
  logic        busy_o, done_o, fail_o, timeout_o;
  logic [15:0] result_o;
  logic        mgmt_req_o, mgmt_we_o;
  logic [4:0]  mgmt_phy_o, mgmt_reg_o;
  logic [15:0] mgmt_wdata_o;
  logic        mgmt_ack_i = 1'b0;
  logic [15:0] mgmt_rdata_i = 16'h0;

  always #2 clk = ~clk;

  cable_diag_seq u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .test_sel_i(test_sel_i),
    .set_idx_i(set_idx_i), .timeout_limit_i(timeout_limit_i),
    .busy_o(busy_o), .done_o(done_o), .result_o(result_o), .fail_o(fail_o),
    .timeout_o(timeout_o), .mgmt_req_o(mgmt_req_o), .mgmt_we_o(mgmt_we_o),
    .mgmt_phy_o(mgmt_phy_o), .mgmt_reg_o(mgmt_reg_o), .mgmt_wdata_o(mgmt_wdata_o),
    .mgmt_ack_i(mgmt_ack_i), .mgmt_rdata_i(mgmt_rdata_i)
  );

  int total = 0;
  int bad = 0;

  // PHY model state and transaction log
  logic [15:0] ctl_m;
  logic [15:0] res_val;
  int          done_after;
  bit          cfg_fail;
  bit          cfg_len;
  int          polls;
  int          lg_n;
  logic [4:0]  lg_addr [0:63];
  logic        lg_we   [0:63];
  logic [15:0] lg_data [0:63];
  int          sts_reads, res_reads, phy_bad, hold_bad;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    chk(act == exp, tag, act, exp);
  endtask

  // Management responder: acks each request after two cycles, and watches the handshake.
  initial begin
    int  lat;
    bit  p_req, p_ack;
    logic [4:0]  p_reg;
    logic        p_we;
    logic [15:0] p_wd;
    lat = 0; p_req = 0; p_ack = 0; p_reg = '0; p_we = 0; p_wd = '0;
    forever begin
      @(negedge clk);
      if (p_req && !p_ack) begin
        if (!(mgmt_req_o && mgmt_reg_o == p_reg && mgmt_we_o == p_we && mgmt_wdata_o == p_wd))
          hold_bad++;
      end
      if (p_ack && mgmt_req_o) hold_bad++;
      p_req = mgmt_req_o; p_reg = mgmt_reg_o; p_we = mgmt_we_o; p_wd = mgmt_wdata_o;
      if (mgmt_ack_i) begin
        mgmt_ack_i = 1'b0;
      end else if (mgmt_req_o) begin
        if (lat < 2) lat++;
        else begin
          lat = 0;
          mgmt_ack_i = 1'b1;
          if (mgmt_phy_o != 5'd1) phy_bad++;
          if (lg_n < 64) begin
            lg_addr[lg_n] = mgmt_reg_o; lg_we[lg_n] = mgmt_we_o; lg_data[lg_n] = mgmt_wdata_o;
          end
          lg_n++;
          if (mgmt_we_o) begin
            if (mgmt_reg_o == 5'h1E) ctl_m = mgmt_wdata_o;
            mgmt_rdata_i = 16'hDEAD;
          end else if (mgmt_reg_o == 5'h1E) begin
            mgmt_rdata_i = ctl_m;
          end else if (mgmt_reg_o == 5'h1F) begin
            sts_reads++;
            if (polls >= done_after) begin
              if (cfg_len) mgmt_rdata_i = 16'h8000;
              else mgmt_rdata_i = cfg_fail ? 16'h6000 : 16'h2000;
            end else begin
              // noise in the other test's bits
              mgmt_rdata_i = cfg_len ? 16'h6000 : 16'h8000;
            end
            polls++;
          end else if (mgmt_reg_o == 5'h1D) begin
            res_reads++;
            mgmt_rdata_i = res_val;
          end else begin
            mgmt_rdata_i = 16'h0000;
          end
        end
      end
      p_ack = mgmt_ack_i;
    end
  end

  logic [15:0] o_res;
  logic        o_fail, o_to;
  int          o_done_cycles;
  bit          o_busy_after;

  task automatic setup(input logic [15:0] ctl0, input bit len, input int dn, input bit f, input logic [15:0] rv);
    ctl_m = ctl0; cfg_len = len; done_after = dn; cfg_fail = f; res_val = rv;
    polls = 0; lg_n = 0; sts_reads = 0; res_reads = 0;
  endtask

  task automatic pulse_start(input bit len, input logic [2:0] idx);
    @(negedge clk);
    test_sel_i = len; set_idx_i = idx; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done();
    int guard;
    guard = 0;
    while (!done_o && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    o_res = result_o; o_fail = fail_o; o_to = timeout_o;
    o_done_cycles = 0;
    while (done_o) begin
      o_done_cycles++;
      @(negedge clk);
    end
    o_busy_after = busy_o;
  endtask

  task automatic t_reset();
    chk_eq("R1 busy after reset", busy_o, 0);
    chk_eq("R1 done after reset", done_o, 0);
    chk_eq("R1 req after reset", mgmt_req_o, 0);
    chk_eq("R1 result after reset", result_o, 0);
    chk_eq("R1 flags after reset", {fail_o, timeout_o}, 0);
  endtask

  task automatic t_refl_pass();
    setup(16'hA0C5, 1'b0, 2, 1'b0, 16'h1234);
    timeout_limit_i = 8'd20;
    pulse_start(1'b0, 3'd3);
    wait_done();
    chk_eq("R2 txn count", lg_n, 8);
    chk_eq("R2 first read ctl", {lg_we[0], lg_addr[0]}, {1'b0, 5'h1E});
    chk_eq("R2 select write", {lg_we[1], lg_addr[1], lg_data[1]}, {1'b1, 5'h1E, 16'hA3C5});
    chk_eq("R2 second read ctl", {lg_we[2], lg_addr[2]}, {1'b0, 5'h1E});
    chk_eq("R2 start write bit12", {lg_we[3], lg_addr[3], lg_data[3]}, {1'b1, 5'h1E, 16'hB3C5});
    chk_eq("R4 status reads", sts_reads, 3);
    chk_eq("R4 result addr", {lg_we[7], lg_addr[7]}, {1'b0, 5'h1D});
    chk_eq("R4 result value", o_res, 16'h1234);
    chk_eq("R4 no fail/timeout", {o_fail, o_to}, 0);
    chk_eq("R2 phy addr", phy_bad, 0);
    chk_eq("R9 done width", o_done_cycles, 1);
    chk_eq("R9 busy after done", o_busy_after, 0);
  endtask

  task automatic t_len_pass();
    setup(16'h0F0F, 1'b1, 1, 1'b0, 16'h00A7);
    timeout_limit_i = 8'd20;
    pulse_start(1'b1, 3'd2);
    wait_done();
    chk_eq("R3 select code 6", lg_data[1], 16'h0E0F);
    chk_eq("R3 start bit13", lg_data[3], 16'h2E0F);
    chk_eq("R4 len status reads", sts_reads, 2);
    chk_eq("R5 len ignores bit14", o_fail, 0);
    chk_eq("R4 len result", o_res, 16'h00A7);
    chk_eq("R9 len done width", o_done_cycles, 1);
  endtask

  task automatic t_refl_fail();
    setup(16'h0000, 1'b0, 0, 1'b1, 16'h5555);
    timeout_limit_i = 8'd20;
    pulse_start(1'b0, 3'd4);
    wait_done();
    chk_eq("R2 idx 4 select", lg_data[1], 16'h0400);
    chk_eq("R5 fail flag", o_fail, 1);
    chk_eq("R5 no result read", res_reads, 0);
    chk_eq("R5 result cleared", o_res, 0);
    chk_eq("R5 txn count", lg_n, 5);
  endtask

  task automatic t_timeout();
    int n0;
    setup(16'h0000, 1'b0, 1000, 1'b0, 16'h7777);
    timeout_limit_i = 8'd4;
    pulse_start(1'b0, 3'd0);
    wait_done();
    chk_eq("R6 timeout flag", o_to, 1);
    chk_eq("R6 fail clear on timeout", o_fail, 0);
    chk_eq("R6 status reads", sts_reads, 4);
    chk_eq("R6 no result read", res_reads, 0);
    n0 = lg_n;
    repeat (20) @(negedge clk);
    chk_eq("R6 quiet after timeout", lg_n, n0);
  endtask

  task automatic t_edge_limit();
    setup(16'h0000, 1'b0, 3, 1'b0, 16'h0BEE);
    timeout_limit_i = 8'd4;
    pulse_start(1'b0, 3'd1);
    wait_done();
    chk_eq("R6 done on last poll no timeout", o_to, 0);
    chk_eq("R6 last poll result", o_res, 16'h0BEE);
    chk_eq("R6 last poll reads", sts_reads, 4);
  endtask

  task automatic t_busy_start();
    setup(16'h0000, 1'b0, 5, 1'b0, 16'hC0DE);
    timeout_limit_i = 8'd20;
    pulse_start(1'b0, 3'd2);
    repeat (6) @(negedge clk);
    start_i = 1'b1; test_sel_i = 1'b1; set_idx_i = 3'd0;
    @(negedge clk);
    start_i = 1'b0;
    repeat (15) @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done();
    chk_eq("R8 select unaffected", lg_data[1], 16'h0200);
    chk_eq("R8 start bit unaffected", lg_data[3], 16'h1200);
    chk_eq("R8 txn count", lg_n, 11);
    chk_eq("R8 result", o_res, 16'hC0DE);
    repeat (10) @(negedge clk);
    chk_eq("R8 stays idle", busy_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    ctl_m = '0; res_val = '0; done_after = 0; cfg_fail = 0; cfg_len = 0; polls = 0;
    lg_n = 0; sts_reads = 0; res_reads = 0; phy_bad = 0; hold_bad = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_refl_pass();
    t_len_pass();
    t_refl_fail();
    t_timeout();
    t_edge_limit();
    t_busy_start();
    chk_eq("R7 handshake violations", hold_bad, 0);
    chk_eq("R2 phy addr overall", phy_bad, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule